// File: doc/BRIEF.md
# SONET frame-aligning deserializer

This block accepts a recovered line bit stream, one bit per clock of the serial clock domain, and groups it into 8-bit bytes. The first bit received in a byte lands in the most significant bit. In parallel it looks for the SONET/SDH framing word. That word is three A1 bytes (0xF6) followed directly by three A2 bytes (0x28), 48 bits in all. When the word is found, the block realigns both the byte boundary and the frame boundary in one step.

The search is gated by an out-of-frame control driven by external overhead logic. A rising edge on that control arms the search, and it stays armed while the control remains high. While the search is disarmed, the byte phase is frozen. A framing word that appears at any other bit offset is then ignored. A framing word that lands exactly on the frozen phase is still reported with a frame pulse.

Top module: `sonet_frame_deser`

## Requirements
- R1: Synchronous active-high `rst` clears the byte phase and the bit history. While reset is applied, `byte_out` is 0x00 and `byte_stb` and `frame_pulse` are low. The first strobe after release appears in the cycle after the eighth bit is sampled.
- R2: Without a realignment, `byte_stb` is high for one cycle in every 8. `byte_out` changes only with the strobe. It then holds the last 8 bits sampled, with the earliest of them in bit 7.
- R3: If the last 48 sampled bits equal F6 F6 F6 28 28 28 (MSB first) while the search is enabled, then in the next cycle `byte_stb` and `frame_pulse` are high and `byte_out` is 0x28. This holds whatever the previous byte phase was.
- R4: After a realignment, the next strobe comes exactly 8 clocks after the realigning strobe.
- R5: The search applies to a sampled bit when `oof_in` was high at the previous clock edge. A rising edge of `oof_in` therefore arms it, and it stays armed while `oof_in` stays high. Reset leaves it armed.
- R6: While the search is disabled, a framing word that ends off the current byte boundary causes no frame pulse and no extra strobe, and the byte phase is unchanged.
- R7: While the search is disabled, a framing word whose last bit completes a byte on the current phase raises `frame_pulse` together with that byte (0x28).
- R8: `frame_pulse` is never high without `byte_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_in | input | 1 | Recovered serial data bit |
| oof_in | input | 1 | Out-of-frame control; high arms the boundary search |
| byte_out | output | 8 | Aligned parallel byte, first received bit in bit 7 |
| byte_stb | output | 1 | One-cycle strobe marking a new value on `byte_out` |
| frame_pulse | output | 1 | Marks the byte that completes a framing word |

## Verification
A framing match and an ordinary byte boundary can fall in the same cycle. If the search is armed and the word already sits on the current phase, the two events must merge into one strobe, not two. If the search is disarmed, the same coincidence is the only case that still produces a frame pulse. The bench creates both situations. It inserts words at arbitrary offsets, and when the reference byte phase is zero it also inserts words exactly on the boundary, while `oof_in` is held high, held low and toggled. A per-cycle reference model judges every strobe, byte and frame pulse, and the run also confirms that in-window realignments, ignored off-phase words and held-phase frame pulses each occurred.

// File: rtl/sonet_frame_deser.sv
module sonet_frame_deser #(
  parameter int              BYTE_W = 8,
  parameter int              A1_CNT = 3,
  parameter int              A2_CNT = 3,
  parameter logic [BYTE_W-1:0] A1   = 8'hF6,
  parameter logic [BYTE_W-1:0] A2   = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd_in,
  input  logic              oof_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_pulse
);
  localparam int PAT_W = (A1_CNT + A2_CNT) * BYTE_W;
  localparam int CW    = $clog2(BYTE_W);
  localparam logic [PAT_W-1:0] PAT = {{A1_CNT{A1}}, {A2_CNT{A2}}};
  localparam logic [CW-1:0]    LAST = CW'(BYTE_W - 1);

  logic [PAT_W-1:0] sh;
  logic [PAT_W-1:0] win;
  logic [CW-1:0]    cnt;
  logic             srch;
  logic             hit, emit;

  assign win  = {sh[PAT_W-2:0], sd_in};
  assign hit  = (win == PAT);
  assign emit = (cnt == LAST) | (hit & srch);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      cnt         <= '0;
      srch        <= 1'b1;
      byte_out    <= '0;
      byte_stb    <= 1'b0;
      frame_pulse <= 1'b0;
    end else begin
      sh          <= win;
      srch        <= oof_in;
      cnt         <= emit ? '0 : cnt + CW'(1);
      byte_stb    <= emit;
      frame_pulse <= hit & emit;
      if (emit) byte_out <= win[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/sonet_frame_deser_chk.sv
module sonet_frame_deser_chk #(
  parameter int                BYTE_W = 8,
  parameter logic [BYTE_W-1:0] A2     = 8'h28
) (
  input logic              clk,
  input logic              rst,
  input logic              oof_in,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_stb,
  input logic              frame_pulse
);
  int   span;
  logic oof_d1, oof_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      span   <= 0;
      oof_d1 <= 1'b1;
      oof_d2 <= 1'b1;
    end else begin
      span   <= byte_stb ? 1 : span + 1;
      oof_d1 <= oof_in;
      oof_d2 <= oof_d1;
    end
  end

  assert_frame_has_stb_R8: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> byte_stb);

  assert_frame_byte_R3: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> byte_out == A2);

  assert_full_span_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !frame_pulse) |-> span == BYTE_W);

  assert_short_only_armed_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && span != BYTE_W) |-> (frame_pulse && oof_d2));
endmodule

bind sonet_frame_deser sonet_frame_deser_chk #(.BYTE_W(BYTE_W), .A2(A2)) u_chk (
  .clk(clk), .rst(rst), .oof_in(oof_in), .byte_out(byte_out),
  .byte_stb(byte_stb), .frame_pulse(frame_pulse)
);

// File: tb/tb_sonet_frame_deser.sv
`timescale 1ns/1ps
module tb_sonet_frame_deser;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sd_in = 1'b0;
  logic       oof_in = 1'b1;
  logic [7:0] byte_out;
  logic       byte_stb, frame_pulse;

  always #5 clk = ~clk;

  sonet_frame_deser dut (
    .clk(clk), .rst(rst), .sd_in(sd_in), .oof_in(oof_in),
    .byte_out(byte_out), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
  );

  localparam logic [47:0] WORD = 48'hF6F6F6_282828;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [47:0] hist;
  int          ph;
  bit          en;
  logic        exp_stb, exp_fp;
  logic [7:0]  exp_byte;
  string       tag;
  int n_realign = 0, n_ignored = 0, n_held = 0;
  bit gq[$];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    hist = '0; ph = 0; en = 1'b1;
    exp_stb = 1'b0; exp_fp = 1'b0; exp_byte = 8'h00;
  endtask

  task automatic step(input bit b, input bit o);
    logic [47:0] w;
    bit m, bnd, re;
    sd_in = b; oof_in = o;
    w   = {hist[46:0], b};
    m   = (w == WORD);
    bnd = (ph == 7);
    re  = m && en;
    tag = "R2";
    if (m && en)  begin tag = bnd ? "R3" : "R4"; n_realign++; end
    if (m && !en) begin tag = bnd ? "R7" : "R6"; if (bnd) n_held++; else n_ignored++; end
    if (!en && !m) tag = "R6";
    exp_fp  = m && (en || bnd);
    exp_stb = re || bnd;
    if (exp_stb) begin exp_byte = w[7:0]; ph = 0; end
    else ph++;
    hist = w;
    en = o;
    @(negedge clk);
    chk(tag, {7'b0, byte_stb}, {7'b0, exp_stb}, "byte_stb");
    chk(tag, {7'b0, frame_pulse}, {7'b0, exp_fp}, "frame_pulse");
    chk(tag, byte_out, exp_byte, "byte_out");
  endtask

  function automatic bit oof_at(input int c);
    if (c < 2500) return 1'b1;
    if (c < 5000) return 1'b0;
    return ((c / 250) % 2) == 0;
  endfunction

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", byte_out, 8'h00, "byte_out in reset");
    chk("R1", {7'b0, byte_stb}, 8'h00, "byte_stb in reset");
    chk("R1", {7'b0, frame_pulse}, 8'h00, "frame_pulse in reset");
    rst = 1'b0;
    for (int c = 0; c < 8000; c++) begin
      if (gq.size() == 0) begin
        if (!oof_at(c) && ph == 0 && $urandom_range(0, 2) == 0) begin
          for (int i = 47; i >= 0; i--) gq.push_back(WORD[i]);
        end else if ($urandom_range(0, 3) == 0) begin
          for (int i = 47; i >= 0; i--) gq.push_back(WORD[i]);
        end else begin
          for (int i = 0; i < int'($urandom_range(1, 40)); i++) gq.push_back(1'($urandom_range(0, 1)));
        end
      end
      step(gq.pop_front(), oof_at(c));
    end
    checks++;
    if (n_realign == 0) begin errors++; $display("FAIL R5 realign count actual 0 expected >0"); end
    checks++;
    if (n_ignored == 0) begin errors++; $display("FAIL R6 ignored count actual 0 expected >0"); end
    checks++;
    if (n_held == 0) begin errors++; $display("FAIL R7 held frame count actual 0 expected >0"); end
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", byte_out, 8'h00, "byte_out after reset");
    chk("R1", {7'b0, byte_stb}, 8'h00, "byte_stb after reset");
    model_reset();
    rst = 1'b0;
    for (int c = 0; c < 40; c++) step(1'($urandom_range(0, 1)), 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule